// File: doc/BRIEF.md
# Store Epoch Tagger

This block sits between a processor's write-through store path and the coherence fabric. It tags every outgoing store so that the home directories can enforce release ordering themselves. The processor therefore never waits for a per-store acknowledgment. Relaxed stores pass straight through and carry only the current epoch number as a small tag. The tagger keeps a count of Relaxed stores per destination directory for the epoch that is open.

A Release store closes the epoch. Its message carries three things: the epoch number, every per-directory count, and a bitmask of the directories that received Relaxed stores in that epoch. A directory can then check that all earlier Relaxed stores have arrived before it makes the Release visible. After the Release, the counts clear and the epoch number advances.

Each closed epoch holds an entry in a small table until the directory side returns a completion carrying that epoch number. Completions may arrive in any order. When the table cannot accept a new epoch, the store input is held off. When a per-directory count is about to wrap, the tagger closes the epoch on its own with a barrier message, then lets the waiting store through.

Top module: `store_epoch_tagger`

## Requirements
- R1: After reset the epoch number is 0, every count is 0 and no epoch is outstanding. The first Release carries epoch 0, all-zero counts and an empty pending mask, and the block is ready when the sink is ready.
- R2: A Relaxed store (st_release=0) is offered on the message output in the same cycle with msg_kind=0. It carries its directory, address, data and the current epoch as its tag, with msg_counts and msg_pending both zero. It is accepted whenever msg_ready is high and its counter is below the maximum, even while the epoch table is full.
- R3: Each accepted Relaxed store adds one to the count of its destination directory for the open epoch.
- R4: A Release store (st_release=1) is sent with msg_kind=1 and carries the open epoch number. The count of directory d is at msg_counts[d*CNT_W +: CNT_W]. Bit d of msg_pending is set exactly when that count is nonzero.
- R5: After a Release or barrier message is accepted, the epoch number advances by one modulo 2^EPOCH_W and all counts return to zero.
- R6: A Release store is held (st_ready=0, msg_valid=0) in either of two cases: all TBL_DEPTH table entries hold outstanding epochs, or an outstanding entry still holds the current epoch number.
- R7: A completion whose epoch matches an outstanding entry frees that entry, in any order. A completion matching no outstanding entry changes nothing.
- R8: When a Relaxed store targets a directory whose count is at its maximum (2^CNT_W-1), the block first sends a barrier message (msg_kind=2, zero directory/address/data) carrying the epoch, counts and pending mask, and keeps st_ready low. In the next cycle it sends the store as a Relaxed store in the new epoch.
- R9: While msg_ready is low, st_ready is low and no count, epoch or table state changes.
- R10: A barrier needs a table entry just as a Release does, and is held off, with the store, under the conditions of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle |
| st_release | input | 1 | 1 = Release store, 0 = Relaxed store |
| st_dir | input | DIR_W | Destination directory, below NUM_DIRS |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| msg_valid | output | 1 | Message offered to the fabric |
| msg_ready | input | 1 | Fabric accepts the message |
| msg_kind | output | 2 | 0 Relaxed, 1 Release, 2 barrier |
| msg_dir | output | DIR_W | Destination directory (0 for barrier) |
| msg_addr | output | ADDR_W | Address (0 for barrier) |
| msg_data | output | DATA_W | Data (0 for barrier) |
| msg_epoch | output | EPOCH_W | Open epoch number |
| msg_counts | output | NUM_DIRS*CNT_W | Per-directory Relaxed counts (epoch-closing messages only) |
| msg_pending | output | NUM_DIRS | Directories with Relaxed stores in the closing epoch |
| cmp_valid | input | 1 | Epoch completion returned by a directory |
| cmp_epoch | input | EPOCH_W | Epoch number being completed |

## Verification
The assertions assume four things about the inputs:
- st_dir always names an existing directory.
- A store, once offered, keeps its payload until it is taken.
- Completions name only epochs that were actually sent.
- A completion is never repeated while its epoch number might be reused.

The stimulus keeps within these assumptions. Every store is held steady until st_ready is seen, and the only stray completion is one deliberately sent for an epoch that is not outstanding. Completions are issued only after the matching message has been scored. The scenarios drive the table into both the full state and the epoch-number alias state, and then free it out of order.

// File: rtl/tagger_pkg.sv
// Shared encodings for the store epoch tagger.
// Assumes: message kinds fit in two bits and are decoded downstream by value.
package tagger_pkg;

    typedef enum logic [1:0] {
        KIND_RELAXED = 2'd0,
        KIND_RELEASE = 2'd1,
        KIND_BARRIER = 2'd2
    } msg_kind_e;

endpackage

// File: rtl/epoch_dir_counters.sv
// Per-directory Relaxed store counters for the open epoch.
// Does: one counter per directory, cleared as a group when an epoch closes.
// Assumes: inc_en and clr are never asserted together; inc_dir < NUM_DIRS.
module epoch_dir_counters #(
    parameter int NUM_DIRS = 4,
    parameter int CNT_W    = 4,
    parameter int DIR_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      inc_en,
    input  logic [DIR_W-1:0]          inc_dir,
    input  logic                      clr,
    output logic [NUM_DIRS*CNT_W-1:0] counts_flat,
    output logic [NUM_DIRS-1:0]       pending,
    output logic [NUM_DIRS-1:0]       at_max
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        logic [CNT_W-1:0] cnt_q;

        // Count Relaxed stores to this directory; clear on epoch close.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (clr) begin
                cnt_q <= '0;
            end else if (inc_en && (inc_dir == DIR_W'(g))) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        assign counts_flat[g*CNT_W +: CNT_W] = cnt_q;
        assign pending[g]                    = (cnt_q != '0);
        assign at_max[g]                     = (cnt_q == CNT_MAX);
    end

endmodule

// File: rtl/epoch_table.sv
// Table of closed epochs awaiting completion from the directory side.
// Does: allocates the lowest free entry for each closed epoch, frees an entry
//       when a completion carries its epoch, reports when a new epoch cannot
//       be tracked (table full, or the current number is still outstanding).
// Assumes: alloc_en is only raised while busy is low.
module epoch_table #(
    parameter int DEPTH   = 4,
    parameter int EPOCH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_en,
    input  logic [EPOCH_W-1:0] alloc_epoch,
    input  logic               cmp_valid,
    input  logic [EPOCH_W-1:0] cmp_epoch,
    input  logic [EPOCH_W-1:0] cur_epoch,
    output logic               busy
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] valid_vec;
    logic [DEPTH-1:0] alias_vec;
    logic [IDX_W-1:0] alloc_idx;

    // Pick the lowest-numbered free entry.
    always_comb begin
        alloc_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                alloc_idx = IDX_W'(i);
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic               valid_q;
        logic [EPOCH_W-1:0] ep_q;
        logic               hit;

        assign hit = cmp_valid && valid_q && (ep_q == cmp_epoch);

        // Hold one outstanding epoch; fill on allocate, drop on completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                ep_q    <= '0;
            end else if (alloc_en && !valid_q && (alloc_idx == IDX_W'(g))) begin
                valid_q <= 1'b1;
                ep_q    <= alloc_epoch;
            end else if (hit) begin
                valid_q <= 1'b0;
            end
        end

        assign valid_vec[g] = valid_q;
        assign alias_vec[g] = valid_q && (ep_q == cur_epoch);
    end

    assign busy = (&valid_vec) || (|alias_vec);

endmodule

// File: rtl/store_epoch_tagger.sv
// Source-side store epoch tagger (top).
// Does: passes Relaxed stores through tagged with the open epoch, closes the
//       epoch on a Release (or on a counter about to wrap, via a barrier),
//       and stalls the store port when the closed-epoch table cannot accept.
// Assumes: store payload is stable while st_valid is high and st_ready low;
//          completions only name epochs that were sent.
module store_epoch_tagger #(
    parameter int NUM_DIRS  = 4,
    parameter int CNT_W     = 4,
    parameter int EPOCH_W   = 3,
    parameter int TBL_DEPTH = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    localparam int DIR_W    = (NUM_DIRS > 1) ? $clog2(NUM_DIRS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      st_valid,
    output logic                      st_ready,
    input  logic                      st_release,
    input  logic [DIR_W-1:0]          st_dir,
    input  logic [ADDR_W-1:0]         st_addr,
    input  logic [DATA_W-1:0]         st_data,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [1:0]                msg_kind,
    output logic [DIR_W-1:0]          msg_dir,
    output logic [ADDR_W-1:0]         msg_addr,
    output logic [DATA_W-1:0]         msg_data,
    output logic [EPOCH_W-1:0]        msg_epoch,
    output logic [NUM_DIRS*CNT_W-1:0] msg_counts,
    output logic [NUM_DIRS-1:0]       msg_pending,
    input  logic                      cmp_valid,
    input  logic [EPOCH_W-1:0]        cmp_epoch
);

    import tagger_pkg::*;

    logic [EPOCH_W-1:0]        cur_epoch_q;
    logic [NUM_DIRS*CNT_W-1:0] counts_flat;
    logic [NUM_DIRS-1:0]       pending_vec;
    logic [NUM_DIRS-1:0]       at_max_vec;
    logic                      tbl_busy;
    logic                      need_bar;
    logic                      needs_entry;
    logic                      blocked;
    logic                      msg_fire;
    logic                      close_fire;
    logic                      rlx_fire;
    msg_kind_e                 kind;

    // Decide whether this store closes an epoch and whether it must wait.
    always_comb begin
        need_bar    = st_valid && !st_release && at_max_vec[st_dir];
        needs_entry = st_valid && (st_release || need_bar);
        blocked     = needs_entry && tbl_busy;
    end

    assign msg_valid  = st_valid && !blocked;
    assign st_ready   = msg_ready && !blocked && !need_bar;
    assign msg_fire   = msg_valid && msg_ready;
    assign close_fire = msg_fire && needs_entry;
    assign rlx_fire   = msg_fire && !needs_entry;

    // Form the outgoing message fields.
    always_comb begin
        if (need_bar) begin
            kind = KIND_BARRIER;
        end else if (st_release) begin
            kind = KIND_RELEASE;
        end else begin
            kind = KIND_RELAXED;
        end
        msg_kind    = kind;
        msg_dir     = need_bar ? '0 : st_dir;
        msg_addr    = need_bar ? '0 : st_addr;
        msg_data    = need_bar ? '0 : st_data;
        msg_epoch   = cur_epoch_q;
        msg_counts  = needs_entry ? counts_flat : '0;
        msg_pending = needs_entry ? pending_vec : '0;
    end

    // Advance the open epoch number whenever an epoch-closing message leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_epoch_q <= '0;
        end else if (close_fire) begin
            cur_epoch_q <= cur_epoch_q + 1'b1;
        end
    end

    epoch_dir_counters #(
        .NUM_DIRS (NUM_DIRS),
        .CNT_W    (CNT_W),
        .DIR_W    (DIR_W)
    ) u_counters (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_en      (rlx_fire),
        .inc_dir     (st_dir),
        .clr         (close_fire),
        .counts_flat (counts_flat),
        .pending     (pending_vec),
        .at_max      (at_max_vec)
    );

    epoch_table #(
        .DEPTH   (TBL_DEPTH),
        .EPOCH_W (EPOCH_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (close_fire),
        .alloc_epoch (cur_epoch_q),
        .cmp_valid   (cmp_valid),
        .cmp_epoch   (cmp_epoch),
        .cur_epoch   (cur_epoch_q),
        .busy        (tbl_busy)
    );

endmodule

// File: rtl/store_epoch_tagger_chk.sv
// Assertion checker for the store epoch tagger, bound to the top module.
// Does: checks handshake, message-field and epoch-sequencing properties.
// Assumes: attached through the bind at the end of this file.
module store_epoch_tagger_chk #(
    parameter int NUM_DIRS = 4,
    parameter int CNT_W    = 4,
    parameter int EPOCH_W  = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      st_valid,
    input logic                      st_ready,
    input logic                      st_release,
    input logic                      msg_valid,
    input logic                      msg_ready,
    input logic [1:0]                msg_kind,
    input logic [EPOCH_W-1:0]        msg_epoch,
    input logic [NUM_DIRS*CNT_W-1:0] msg_counts,
    input logic [NUM_DIRS-1:0]       msg_pending,
    input logic                      tbl_busy
);

    logic closing;
    assign closing = msg_valid && msg_ready && (msg_kind != 2'd0);

    AST_READY_NEEDS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready |-> msg_ready); // R9

    AST_RLX_NO_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd0) |-> (msg_counts == '0 && msg_pending == '0)); // R2

    AST_RLX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && msg_kind == 2'd0) |-> st_ready); // R2

    AST_EPOCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        closing |=> (msg_epoch == EPOCH_W'($past(msg_epoch) + 1'b1))); // R5

    AST_EPOCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !closing |=> $stable(msg_epoch)); // R5

    AST_BARRIER_HOLDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd2) |-> !st_ready); // R8

    AST_BUSY_BLOCKS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_busy && st_valid && st_release) |-> (!msg_valid && !st_ready)); // R6

endmodule

bind store_epoch_tagger store_epoch_tagger_chk #(
    .NUM_DIRS (NUM_DIRS),
    .CNT_W    (CNT_W),
    .EPOCH_W  (EPOCH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_valid    (st_valid),
    .st_ready    (st_ready),
    .st_release  (st_release),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_kind    (msg_kind),
    .msg_epoch   (msg_epoch),
    .msg_counts  (msg_counts),
    .msg_pending (msg_pending),
    .tbl_busy    (tbl_busy)
);

// File: tb/store_epoch_tagger_bench.sv
// Scoreboard bench for the store epoch tagger.
module store_epoch_tagger_bench;

    localparam int ND = 4;
    localparam int CW = 4;
    localparam int EW = 3;
    localparam int CMAX = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            st_valid = 1'b0;
    logic            st_ready;
    logic            st_release = 1'b0;
    logic [1:0]      st_dir = '0;
    logic [15:0]     st_addr = '0;
    logic [15:0]     st_data = '0;
    logic            msg_valid;
    logic            msg_ready = 1'b1;
    logic [1:0]      msg_kind;
    logic [1:0]      msg_dir;
    logic [15:0]     msg_addr;
    logic [15:0]     msg_data;
    logic [EW-1:0]   msg_epoch;
    logic [ND*CW-1:0] msg_counts;
    logic [ND-1:0]   msg_pending;
    logic            cmp_valid = 1'b0;
    logic [EW-1:0]   cmp_epoch = '0;

    always #5 clk = ~clk;

    store_epoch_tagger u_store_epoch_tagger (
        .clk (clk), .rst_n (rst_n),
        .st_valid (st_valid), .st_ready (st_ready), .st_release (st_release),
        .st_dir (st_dir), .st_addr (st_addr), .st_data (st_data),
        .msg_valid (msg_valid), .msg_ready (msg_ready), .msg_kind (msg_kind),
        .msg_dir (msg_dir), .msg_addr (msg_addr), .msg_data (msg_data),
        .msg_epoch (msg_epoch), .msg_counts (msg_counts), .msg_pending (msg_pending),
        .cmp_valid (cmp_valid), .cmp_epoch (cmp_epoch)
    );

    typedef struct packed {
        logic [1:0]       kind;
        logic [1:0]       dir;
        logic [15:0]      addr;
        logic [15:0]      data;
        logic [EW-1:0]    epoch;
        logic [ND*CW-1:0] counts;
        logic [ND-1:0]    pending;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    int   m_cnt[ND];
    int   m_ep = 0;
    bit   reported = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Build the expected epoch-closing message from the model, then close the epoch.
    function automatic exp_t close_epoch(input logic [1:0] kind, input int dir, input int addr, input int data);
        exp_t e;
        e.kind = kind; e.dir = 2'(dir); e.addr = 16'(addr); e.data = 16'(data);
        e.epoch = EW'(m_ep); e.counts = '0; e.pending = '0;
        for (int d = 0; d < ND; d++) begin
            e.counts[d*CW +: CW] = CW'(m_cnt[d]);
            e.pending[d] = (m_cnt[d] != 0);
            m_cnt[d] = 0;
        end
        m_ep = (m_ep + 1) % (1 << EW);
        return e;
    endfunction

    function automatic exp_t relaxed_exp(input int dir, input int addr, input int data);
        exp_t e;
        e.kind = 2'd0; e.dir = 2'(dir); e.addr = 16'(addr); e.data = 16'(data);
        e.epoch = EW'(m_ep); e.counts = '0; e.pending = '0;
        return e;
    endfunction

    // Driver: push expectations, then hold the store until it is taken.
    task automatic send(input bit rel, input int dir, input int addr, input int data);
        if (rel) begin
            q.push_back(close_epoch(2'd1, dir, addr, data));
        end else begin
            if (m_cnt[dir] == CMAX) q.push_back(close_epoch(2'd2, 0, 0, 0));
            q.push_back(relaxed_exp(dir, addr, data));
            m_cnt[dir]++;
        end
        @(posedge clk); #1;
        st_valid = 1'b1; st_release = rel; st_dir = 2'(dir);
        st_addr = 16'(addr); st_data = 16'(data);
        do @(negedge clk); while (!st_ready);
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    // Offer a store that must be held off; check the port, then withdraw it.
    task automatic probe_blocked(input bit rel, input int dir, input string tag);
        @(posedge clk); #1;
        st_valid = 1'b1; st_release = rel; st_dir = 2'(dir); st_addr = 16'h0bad; st_data = 16'h0bad;
        @(negedge clk);
        chk(st_ready == 1'b0, {tag, " st_ready held low"}, st_ready, 0);
        chk(msg_valid == 1'b0, {tag, " msg_valid held low"}, msg_valid, 0);
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic complete(input int ep);
        @(posedge clk); #1;
        cmp_valid = 1'b1; cmp_epoch = EW'(ep);
        @(posedge clk); #1;
        cmp_valid = 1'b0;
    endtask

    // Monitor: pop and compare every message the fabric accepts.
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            exp_t act;
            act = {msg_kind, msg_dir, msg_addr, msg_data, msg_epoch, msg_counts, msg_pending};
            if (q.size() == 0) begin
                chk(1'b0, "R2 unexpected message", act, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                case (e.kind)
                    2'd0:    chk(act == e, "R2/R3 relaxed message", act, e);
                    2'd1:    chk(act == e, "R3/R4/R5 release message", act, e);
                    default: chk(act == e, "R8 barrier message", act, e);
                endcase
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        for (int d = 0; d < ND; d++) m_cnt[d] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(st_ready == 1'b1, "R1 ready after reset", st_ready, 1);
        chk(msg_valid == 1'b0, "R1 idle after reset", msg_valid, 0);

        send(1, 1, 16'h1000, 16'haaaa);                 // R1: epoch 0, empty
        send(0, 0, 16'h0010, 16'h0001);
        send(0, 2, 16'h0020, 16'h0002);
        send(0, 2, 16'h0021, 16'h0003);
        send(0, 3, 16'h0030, 16'h0004);
        send(1, 0, 16'h1001, 16'hbbbb);                 // R4: counts 1,0,2,1

        // R9: sink not ready holds the store and the state
        q.push_back(relaxed_exp(1, 16'h0040, 16'h0005));
        m_cnt[1]++;
        @(posedge clk); #1;
        msg_ready = 1'b0;
        st_valid = 1'b1; st_release = 1'b0; st_dir = 2'd1; st_addr = 16'h0040; st_data = 16'h0005;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(st_ready == 1'b0, "R9 stalled while sink busy", st_ready, 0);
            chk(msg_valid == 1'b1, "R9 message still offered", msg_valid, 1);
        end
        @(posedge clk); #1;
        msg_ready = 1'b1;
        do @(negedge clk); while (!st_ready);
        @(posedge clk); #1;
        st_valid = 1'b0;

        send(1, 2, 16'h1002, 16'hcccc);                 // epoch 2, dir1 count 1
        send(1, 3, 16'h1003, 16'hdddd);                 // epoch 3, table now full
        send(0, 3, 16'h0050, 16'h0006);                 // R2: relaxed passes while full
        probe_blocked(1, 0, "R6 table full");
        complete(5);
        probe_blocked(1, 0, "R7 stray completion ignored");
        complete(2);                                    // R7: out of order
        send(1, 0, 16'h1004, 16'heeee);                 // epoch 4
        complete(1); complete(3); complete(4);
        send(1, 1, 16'h1005, 16'h0105);
        send(1, 1, 16'h1006, 16'h0106);
        send(1, 1, 16'h1007, 16'h0107);                 // epochs 5..7
        complete(5); complete(6); complete(7);
        probe_blocked(1, 2, "R6 epoch number still outstanding");
        complete(0);
        send(1, 2, 16'h1008, 16'h0108);                 // epoch 0 again

        for (int i = 0; i < CMAX; i++) send(0, 1, 16'h2000 + i, i);
        send(0, 1, 16'h2100, 16'h7777);                 // R8: barrier then relaxed
        send(1, 3, 16'h1009, 16'h0109);                 // dir1 count 1 in new epoch

        send(1, 0, 16'h100a, 16'h010a);                 // table full
        for (int i = 0; i < CMAX; i++) send(0, 2, 16'h3000 + i, i);
        probe_blocked(0, 2, "R10 barrier waits for table");
        complete(0);
        send(0, 2, 16'h3100, 16'h8888);

        repeat (4) @(posedge clk);
        chk(q.size() == 0, "R2 all expected messages seen", q.size(), 0);
        report();
    end

endmodule